// File: doc/BRIEF.md
# Sampled Input Glitch Filter

This block conditions four active-low input pins before they reach edge or level detection further on. Each pin first passes through a two-flop synchroniser. A sampling strobe is then built from a single-cycle oscillator enable input. The oscillator rate is optionally pre-divided, then divided down to one strobe per half sampling period, where a sampling period is eight base ticks. A filtered lane takes a sample of its pin on every strobe. It drives its output low only when two strobe samples in a row are low, and drives it high again only when two strobe samples in a row are high.

As a result, a low glitch narrower than half a sampling period can never reach the output, and a low level held for one and a half sampling periods always does. Each pin has its own enable that picks either the filtered lane or the plain synchronised level. The whole block runs on one system clock; the strobes are clock enables, not derived clocks.

Top module: `pin_glitch_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, every output bit is high (inactive), and both the pre-divider count and the strobe count are zero.
- R2: With `div_sel` = 2'b00 or 2'b11, every `osc_tick` is a base tick, and a sampling strobe falls on every fourth base tick. The first strobe falls on the fourth `osc_tick` after reset.
- R3: With `div_sel` = 2'b01, one base tick is produced per 12 `osc_tick` pulses, so a strobe falls on every 48th `osc_tick`. The pre-divider count never reaches 12.
- R4: With `div_sel` = 2'b10, one base tick is produced per 6 `osc_tick` pulses, so a strobe falls on every 24th `osc_tick`.
- R5: On a filtered pin, a low pulse shorter than half a sampling period (four base ticks) never drives the output low.
- R6: On a filtered pin, a low level lasting at least one and a half sampling periods (twelve base ticks) always drives the output low. The output goes low on the cycle after the second consecutive low strobe sample.
- R7: When `filt_en[i]` is 0, `pins_out_n[i]` equals `pins_n[i]` delayed by exactly two clock cycles. The strobe has no effect on that bit.
- R8: A filtered output changes only on the cycle after a strobe. It returns high only after two consecutive high strobe samples, and it holds its value when the last two samples differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the oscillator rate |
| div_sel | input | 2 | Divider choice: 00/11 direct, 01 pre-divide by 12, 10 pre-divide by 6 |
| filt_en | input | 4 | Per-pin select: 1 filtered path, 0 synchronised path only |
| pins_n | input | 4 | Raw active-low pin levels |
| pins_out_n | output | 4 | Conditioned active-low pin levels |

## Verification
The bench measures glitch widths against the half-period boundary. A three-base-tick low must never appear at the output, and a twelve-base-tick low must always appear. A filter that acted on a single sample would pass the short glitch, and one that needed three samples would delay or drop lows near the boundary. In every divider mode, long random runs are compared with an independent model that places strobes from the osc tick count modulo four times the pre-divide. An off-by-one divider, or a pre-divider that forgets the chosen mode, would shift the strobes and flip outputs at the wrong cycle. Bypassed pins are checked for an exact two-cycle delay, which exposes a missing or extra synchroniser stage, or a bypass that still waits for strobes.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  typedef enum logic [1:0] {
    DIV_DIRECT = 2'b00,
    DIV_SLOW   = 2'b01,
    DIV_FAST   = 2'b10,
    DIV_SPARE  = 2'b11
  } div_sel_e;

  // Number of osc ticks per base tick for a given divider choice.
  function automatic int unsigned prediv_len(input logic [1:0] sel,
                                             input int unsigned slow,
                                             input int unsigned fast);
    case (div_sel_e'(sel))
      DIV_SLOW: return slow;
      DIV_FAST: return fast;
      default:  return 1;
    endcase
  endfunction

  // True when a counter sits on (or past) its last value of a cycle of len.
  function automatic logic wrap_hit(input int unsigned cnt,
                                    input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // Next state of a two-sample agreement filter: follow when both agree.
  function automatic logic agree_next(input logic cur, input logic prev,
                                      input logic held);
    if (cur == prev) return cur;
    return held;
  endfunction

endpackage

// File: rtl/pgf_tick_gen.sv
module pgf_tick_gen
  import pgf_pkg::*;
#(
  parameter int unsigned PRE_SLOW = 12,
  parameter int unsigned PRE_FAST = 6,
  parameter int unsigned HALF_DIV = 4,
  localparam int unsigned PW = $clog2(PRE_SLOW + 1),
  localparam int unsigned HW = $clog2(HALF_DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic [1:0]    div_sel,
  output logic          base_tick,
  output logic          sample_tick,
  output logic [PW-1:0] pre_cnt,
  output logic [HW-1:0] half_cnt
);

  int unsigned pre_len;
  logic        pre_last;
  logic        half_last;

  always_comb begin
    pre_len     = prediv_len(div_sel, PRE_SLOW, PRE_FAST);
    pre_last    = wrap_hit(32'(pre_cnt), pre_len);
    half_last   = wrap_hit(32'(half_cnt), HALF_DIV);
    base_tick   = osc_tick && pre_last;
    sample_tick = base_tick && half_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (osc_tick) begin
      if (pre_last) pre_cnt <= '0;
      else          pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
    end else if (base_tick) begin
      if (half_last) half_cnt <= '0;
      else           half_cnt <= half_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pgf_sync2.sv
module pgf_sync2 #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/pgf_pin_lane.sv
module pgf_pin_lane
  import pgf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic sync_in,
  input  logic filt_en,
  output logic filt_q,
  output logic smp_q,
  output logic pin_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b1;
      filt_q <= 1'b1;
    end else if (sample_tick) begin
      smp_q  <= sync_in;
      filt_q <= agree_next(sync_in, smp_q, filt_q);
    end
  end

  assign pin_out = filt_en ? filt_q : sync_in;

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
  import pgf_pkg::*;
#(
  parameter int unsigned N_PINS   = 4,
  parameter int unsigned PRE_SLOW = 12,
  parameter int unsigned PRE_FAST = 6,
  parameter int unsigned HALF_DIV = 4,
  localparam int unsigned PW = $clog2(PRE_SLOW + 1),
  localparam int unsigned HW = $clog2(HALF_DIV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [1:0]        div_sel,
  input  logic [N_PINS-1:0] filt_en,
  input  logic [N_PINS-1:0] pins_n,
  output logic [N_PINS-1:0] pins_out_n
);

  logic              base_tick;
  logic              sample_tick;
  logic [PW-1:0]     pre_cnt;
  logic [HW-1:0]     half_cnt;
  logic [N_PINS-1:0] sync_q;
  logic [N_PINS-1:0] filt_q;
  logic [N_PINS-1:0] smp_q;

  pgf_tick_gen #(
    .PRE_SLOW (PRE_SLOW),
    .PRE_FAST (PRE_FAST),
    .HALF_DIV (HALF_DIV)
  ) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick    (osc_tick),
    .div_sel     (div_sel),
    .base_tick   (base_tick),
    .sample_tick (sample_tick),
    .pre_cnt     (pre_cnt),
    .half_cnt    (half_cnt)
  );

  pgf_sync2 #(.W(N_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_n),
    .q     (sync_q)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_lane
    pgf_pin_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .sync_in     (sync_q[i]),
      .filt_en     (filt_en[i]),
      .filt_q      (filt_q[i]),
      .smp_q       (smp_q[i]),
      .pin_out     (pins_out_n[i])
    );
  end

endmodule

// File: rtl/pin_glitch_filter_chk.sv
module pin_glitch_filter_chk #(
  parameter int unsigned N_PINS   = 4,
  parameter int unsigned PRE_SLOW = 12,
  parameter int unsigned PW       = 4,
  parameter int unsigned HW       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_tick,
  input logic              base_tick,
  input logic              sample_tick,
  input logic [PW-1:0]     pre_cnt,
  input logic [HW-1:0]     half_cnt,
  input logic [N_PINS-1:0] filt_en,
  input logic [N_PINS-1:0] sync_q,
  input logic [N_PINS-1:0] filt_q,
  input logic [N_PINS-1:0] smp_q,
  input logic [N_PINS-1:0] pins_out_n
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pins_out_n == '1 && pre_cnt == '0 && half_cnt == '0)); // R1

  AST_STROBE_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (base_tick && osc_tick)); // R2

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pre_cnt) < PRE_SLOW); // R3

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(filt_q)); // R8

  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    AST_FALL_TWO_LOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(filt_q[i]) |-> $past(sample_tick && !smp_q[i] && !sync_q[i])); // R5

    AST_LOWS_REACH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && !smp_q[i] && !sync_q[i] && filt_en[i])
        |=> (!pins_out_n[i] || !filt_en[i])); // R6

    AST_BYPASS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_en[i] |-> (pins_out_n[i] == sync_q[i])); // R7
  end

endmodule

bind pin_glitch_filter pin_glitch_filter_chk #(
  .N_PINS   (N_PINS),
  .PRE_SLOW (PRE_SLOW),
  .PW       (PW),
  .HW       (HW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .osc_tick    (osc_tick),
  .base_tick   (base_tick),
  .sample_tick (sample_tick),
  .pre_cnt     (pre_cnt),
  .half_cnt    (half_cnt),
  .filt_en     (filt_en),
  .sync_q      (sync_q),
  .filt_q      (filt_q),
  .smp_q       (smp_q),
  .pins_out_n  (pins_out_n)
);

// File: tb/pin_glitch_filter_test.sv
module pin_glitch_filter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic [3:0] filt_en = 4'hF;
  logic [3:0] pins_n = 4'hF;
  logic [3:0] pins_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  pin_glitch_filter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .div_sel    (div_sel),
    .filt_en    (filt_en),
    .pins_n     (pins_n),
    .pins_out_n (pins_out_n)
  );

  // Independent reference: strobe placed by total osc tick count.
  function automatic int unsigned ticks_per_base(input logic [1:0] s);
    if (s == 2'b01) return 12;
    if (s == 2'b10) return 6;
    return 1;
  endfunction

  function automatic bit strobe_at(input int unsigned n, input logic [1:0] s);
    return ((n + 1) % (4 * ticks_per_base(s))) == 0;
  endfunction

  logic [3:0]  m_s1, m_s2, m_smp, m_fq;
  int unsigned m_osc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 4'hF; m_s2 <= 4'hF; m_smp <= 4'hF; m_fq <= 4'hF; m_osc <= 0;
    end else begin
      m_s1 <= pins_n;
      m_s2 <= m_s1;
      if (osc_tick) begin
        m_osc <= m_osc + 1;
        if (strobe_at(m_osc, div_sel)) begin
          m_smp <= m_s2;
          m_fq  <= (m_s2 & m_smp) | (m_fq & (m_s2 | m_smp));
        end
      end
    end
  end

  function automatic logic [3:0] expect_out();
    return (filt_en & m_fq) | (~filt_en & m_s2);
  endfunction

  task automatic check_vec(input string tag, input logic [3:0] act,
                           input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pins_out_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Random run in one mode; every negedge compares against the model.
  task automatic rand_run(input string tag, input logic [1:0] sel,
                          input logic [3:0] en, input int cycles,
                          input int flip_div);
    div_sel = sel;
    filt_en = en;
    pins_n  = 4'hF;
    do_reset();
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check_vec(tag, pins_out_n, expect_out());
      osc_tick = ($urandom % 3) != 0;
      for (int b = 0; b < 4; b++)
        if (($urandom % flip_div) == 0) pins_n[b] = ~pins_n[b];
    end
    pins_n = 4'hF;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_vec("R1 in reset", pins_out_n, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1 after release", pins_out_n, 4'hF);

    // Directed, direct mode, osc_tick every cycle: half period = 4 cycles.
    div_sel = 2'b00; filt_en = 4'hF; osc_tick = 1'b1;
    do_reset();
    begin
      bit seen_low;
      // R5: 3-cycle glitch on bit 0 must never show up.
      seen_low = 1'b0;
      repeat (5) @(negedge clk);
      pins_n[0] = 1'b0;
      repeat (3) @(negedge clk);
      pins_n[0] = 1'b1;
      for (int c = 0; c < 24; c++) begin
        @(negedge clk);
        check_vec("R5 model", pins_out_n, expect_out());
        if (!pins_out_n[0]) seen_low = 1'b1;
      end
      checks++;
      if (seen_low) begin
        errors++;
        $display("FAIL R5: short glitch reached output (actual low, expected high)");
      end
      // R6: 12-cycle low on bit 1 must show up.
      seen_low = 1'b0;
      pins_n[1] = 1'b0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        check_vec("R6 model", pins_out_n, expect_out());
        if (!pins_out_n[1]) seen_low = 1'b1;
      end
      pins_n[1] = 1'b1;
      // R8: return high after two high samples, then stay high.
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        check_vec("R8 model", pins_out_n, expect_out());
        if (!pins_out_n[1]) seen_low = 1'b1;
      end
      checks++;
      if (!seen_low) begin
        errors++;
        $display("FAIL R6: long low never reached output (actual high, expected low)");
      end
      check_vec("R8 recovered", pins_out_n, 4'hF);
    end

    // R7: bypass delay is exactly two cycles, independent of strobes.
    filt_en = 4'h0; osc_tick = 1'b0;
    @(negedge clk);
    pins_n = 4'b1010;
    @(negedge clk);
    check_vec("R7 one cycle", pins_out_n, 4'hF);
    @(negedge clk);
    check_vec("R7 two cycles", pins_out_n, 4'b1010);
    pins_n = 4'hF;
    repeat (3) @(negedge clk);

    rand_run("R2", 2'b00, 4'hF, 6000, 10);
    rand_run("R2 spare code", 2'b11, 4'b0111, 3000, 10);
    rand_run("R3", 2'b01, 4'hF, 30000, 120);
    rand_run("R4", 2'b10, 4'b1101, 20000, 60);
    rand_run("R7", 2'b01, 4'h0, 3000, 8);
    rand_run("R8", 2'b00, 4'hF, 4000, 6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule